// File: doc/BRIEF.md
# Exclusive Victim Line Buffer

This block sits below a direct-mapped first-level cache. It keeps a few lines that the first-level cache has thrown out. When the first-level cache misses, the controller presents the missing line address on the request port. In the same request it also presents the line that the refill will displace. The buffer searches all of its entries at once.

On a match, the matching entry is handed back to the first-level cache in that same cycle. At the clock edge the displaced line takes that entry's place, so the two lines exchange homes. On no match, the requested line comes from the next level and never enters the buffer. The displaced line is written into the buffer instead, taking a free entry or the least recently used one.

A valid line pushed out of the buffer in this way, if it is dirty, is offered on a write-back port with a valid/ready handshake. New requests are held off until that write-back is taken. Because only displaced lines are stored and hits are exchanged, a line address is never held both here and in the first-level cache.

Top module: `victim_buffer`

## Requirements
- R1: A request that misses never stores the requested line address. When the displaced line is valid it is stored, so a later request for the displaced address hits and a later request for the requested address misses.
- R2: A request accepted while an entry holds the requested address raises `hit` in that same cycle, with `hit_data` and `hit_dirty` equal to the stored line and its dirty flag.
- R3: On a hit, at the clock edge the matching entry takes the displaced line's address, data and dirty flag, and the requested address is no longer held. At most one entry ever matches a given address.
- R4: The entry count `ENTRIES` may be 1 to 5, and a single-entry buffer follows all the other requirements.
- R5: On a miss with a valid displaced line, the target entry is the lowest-indexed empty entry if one exists, otherwise the least recently used entry. Every entry written with a valid line becomes the most recently used.
- R6: A displaced line marked invalid (`vic_valid` = 0) is never inserted. On a hit it leaves the matching entry empty, so the next request for that address misses.
- R7: When a miss replaces a valid dirty entry, the next cycle shows `wb_valid` = 1 with that entry's address and data. Replacing a clean entry produces no write-back.
- R8: While `wb_valid` = 1 and `wb_ready` = 0, `req_ready` is 0, the buffer contents do not change and the write-back outputs stay stable. `req_ready` is 1 whenever `wb_valid` = 0 or `wb_ready` = 1.
- R9: After reset no entry is valid, `wb_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A first-level miss is being presented |
| req_ready | output | 1 | Request is accepted this cycle |
| req_addr | input | ADDR_W | Line address of the missing line |
| vic_valid | input | 1 | The displaced first-level line holds valid data |
| vic_dirty | input | 1 | The displaced line is modified |
| vic_addr | input | ADDR_W | Line address of the displaced line |
| vic_data | input | LINE_W | Data of the displaced line |
| hit | output | 1 | Accepted request matched an entry |
| hit_data | output | LINE_W | Data of the matching entry |
| hit_dirty | output | 1 | Dirty flag of the matching entry |
| wb_valid | output | 1 | A dirty line pushed out awaits write-back |
| wb_ready | input | 1 | The next level accepts the write-back |
| wb_addr | output | ADDR_W | Line address of the write-back line |
| wb_data | output | LINE_W | Data of the write-back line |

## Verification
The write-back handshake can complete in the same cycle as a new miss that pushes out a second dirty line. The old line must then leave and the new one load in the same cycle, with no loss and no stall. The bench provokes this with a long run of dense dirty fills into three-entry and one-entry buffers while `wb_ready` toggles pseudo-randomly. At every cycle it compares `req_ready`, `hit`, the hit line and the write-back port against its own array model, in which the acceptance clears the pending line before the new eviction sets it. Swaps landing in a cycle where a write-back is accepted are judged the same way.

// File: rtl/vb_pkg.sv
package vb_pkg;

  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_SWAP  = 2'd1,
    EV_FILL  = 2'd2,
    EV_STALL = 2'd3
  } vb_event_e;

  // Recency rank of one entry after another entry is touched.
  // Rank 0 is most recent; entries younger than the touched one age by one.
  function automatic int unsigned rank_step(input int unsigned own,
                                            input int unsigned pivot,
                                            input bit          is_pivot);
    if (is_pivot)      return 0;
    else if (own < pivot) return own + 1;
    else               return own;
  endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ADDR_W  = 28
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ENTRIES-1:0]               ent_valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]   ent_addr,
  input  logic [ADDR_W-1:0]                probe_addr,
  output logic [ENTRIES-1:0]               match_vec,
  output logic                             any_match,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] match_idx
);
  localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = ent_valid[e] && (ent_addr[e] == probe_addr);
  end

  assign any_match = |match_vec;

  always_comb begin
    match_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) match_idx = IW'(i);
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R3

endmodule

// File: rtl/vb_lru.sv
module vb_lru import vb_pkg::*; #(
  parameter int unsigned ENTRIES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ENTRIES-1:0]  ent_valid,
  input  logic                touch,
  input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] touch_idx,
  output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] repl_idx
);
  localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0][IW-1:0] rank_q;
  logic [ENTRIES-1:0]         oldest_vec;
  logic [IW-1:0]              oldest_idx;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_old
    assign oldest_vec[e] = (rank_q[e] == IW'(ENTRIES - 1));
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (oldest_vec[i]) oldest_idx = IW'(i);
    end
    repl_idx = oldest_idx;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) repl_idx = IW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        rank_q[i] <= IW'(rank_step(int'(rank_q[i]), int'(rank_q[touch_idx]),
                                   touch_idx == IW'(i)));
      end
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1); // R5

  AST_TOUCH_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> (rank_q[$past(touch_idx)] == '0)); // R5

endmodule

// File: rtl/vb_wb.sv
module vb_wb #(
  parameter int unsigned ADDR_W = 28,
  parameter int unsigned LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LINE_W-1:0] load_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else if (load) begin
      wb_valid <= 1'b1;
      wb_addr  <= load_addr;
      wb_data  <= load_data;
    end else if (wb_ready) begin
      wb_valid <= 1'b0;
    end
  end

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data)); // R8

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer import vb_pkg::*; #(
  parameter int unsigned ADDR_W  = 28,
  parameter int unsigned LINE_W  = 128,
  parameter int unsigned ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              vic_valid,
  input  logic              vic_dirty,
  input  logic [ADDR_W-1:0] vic_addr,
  input  logic [LINE_W-1:0] vic_data,
  output logic              hit,
  output logic [LINE_W-1:0] hit_data,
  output logic              hit_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data
);
  localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0]             dirty_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;
  logic [ENTRIES-1:0][LINE_W-1:0] data_q;

  logic [ENTRIES-1:0] match_vec;
  logic               lookup_hit;
  logic [IW-1:0]      hit_idx;
  logic [IW-1:0]      repl_idx;
  logic [IW-1:0]      tgt_idx;

  // Named events for the assertions.
  logic      accept;
  logic      swap_evt;
  logic      fill_evt;
  logic      write_evt;
  logic      touch_evt;
  logic      evict_dirty;
  vb_event_e evt;

  vb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) i_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_valid  (valid_q),
    .ent_addr   (addr_q),
    .probe_addr (req_addr),
    .match_vec  (match_vec),
    .any_match  (lookup_hit),
    .match_idx  (hit_idx)
  );

  vb_lru #(.ENTRIES(ENTRIES)) i_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_valid (valid_q),
    .touch     (touch_evt),
    .touch_idx (tgt_idx),
    .repl_idx  (repl_idx)
  );

  vb_wb #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) i_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (evict_dirty),
    .load_addr (addr_q[repl_idx]),
    .load_data (data_q[repl_idx]),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data)
  );

  assign req_ready   = !wb_valid || wb_ready;
  assign accept      = req_valid && req_ready;
  assign swap_evt    = accept && lookup_hit;
  assign fill_evt    = accept && !lookup_hit && vic_valid;
  assign write_evt   = swap_evt || fill_evt;
  assign touch_evt   = write_evt && vic_valid;
  assign tgt_idx     = swap_evt ? hit_idx : repl_idx;
  assign evict_dirty = fill_evt && valid_q[repl_idx] && dirty_q[repl_idx];

  always_comb begin
    if (req_valid && !req_ready) evt = EV_STALL;
    else if (swap_evt)           evt = EV_SWAP;
    else if (fill_evt)           evt = EV_FILL;
    else                         evt = EV_IDLE;
  end

  assign hit       = swap_evt;
  assign hit_data  = data_q[hit_idx];
  assign hit_dirty = dirty_q[hit_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (write_evt) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (tgt_idx == IW'(i)) begin
          valid_q[i] <= vic_valid;
          dirty_q[i] <= vic_valid && vic_dirty;
          addr_q[i]  <= vic_addr;
          data_q[i]  <= vic_data;
        end
      end
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> (valid_q == '0)); // R9

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EV_STALL) |=> $stable(valid_q) && $stable(addr_q) && $stable(data_q)); // R8

  AST_FILL_KEEPS_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EV_FILL) |=> valid_q[$past(repl_idx)] &&
                         (addr_q[$past(repl_idx)] == $past(vic_addr))); // R1

  AST_SWAP_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EV_SWAP) |=> !valid_q[$past(hit_idx)] ||
                         (addr_q[$past(hit_idx)] != $past(req_addr))); // R3

  AST_INVALID_NOT_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !lookup_hit && !vic_valid |=> $stable(valid_q)); // R6

endmodule

// File: tb/test_victim_buffer.sv
module test_victim_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int LW = 32;
  localparam int NM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          vic_valid = 1'b0;
  logic          vic_dirty = 1'b0;
  logic [AW-1:0] vic_addr = '0;
  logic [LW-1:0] vic_data = '0;
  logic          wb_ready = 1'b1;

  logic          rdy  [2];
  logic          hit  [2];
  logic [LW-1:0] hdat [2];
  logic          hdir [2];
  logic          wbv  [2];
  logic [AW-1:0] wba  [2];
  logic [LW-1:0] wbd  [2];

  victim_buffer #(.ADDR_W(AW), .LINE_W(LW), .ENTRIES(3)) i_victim_buffer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[0]),
    .req_addr(req_addr), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
    .vic_addr(vic_addr), .vic_data(vic_data), .hit(hit[0]), .hit_data(hdat[0]),
    .hit_dirty(hdir[0]), .wb_valid(wbv[0]), .wb_ready(wb_ready),
    .wb_addr(wba[0]), .wb_data(wbd[0]));

  victim_buffer #(.ADDR_W(AW), .LINE_W(LW), .ENTRIES(1)) i_victim_buffer_one (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy[1]),
    .req_addr(req_addr), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
    .vic_addr(vic_addr), .vic_data(vic_data), .hit(hit[1]), .hit_data(hdat[1]),
    .hit_dirty(hdir[1]), .wb_valid(wbv[1]), .wb_ready(wb_ready),
    .wb_addr(wba[1]), .wb_data(wbd[1]));

  // Reference model, one per instance.
  int            m_n [2] = '{3, 1};
  bit            m_v   [2][NM];
  bit            m_d   [2][NM];
  int            m_a   [2][NM];
  logic [LW-1:0] m_dat [2][NM];
  int            m_age [2][NM];
  bit            m_wbv [2];
  int            m_wba [2];
  logic [LW-1:0] m_wbd [2];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int unsigned lcg = 32'h1234_5678;

  function automatic logic [LW-1:0] line_of(input int a, input int salt);
    return LW'(a * 32'h0100_0193 + salt * 32'h0000_9E37 + 32'h0000_0011);
  endfunction

  function automatic bit in_model(input int d, input int a);
    for (int i = 0; i < m_n[d]; i++) if (m_v[d][i] && m_a[d][i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int nextrand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) & 32'h7fff);
  endfunction

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < NM; i++) begin
        m_v[d][i] = 1'b0; m_d[d][i] = 1'b0; m_a[d][i] = 0;
        m_dat[d][i] = '0; m_age[d][i] = i;
      end
      m_wbv[d] = 1'b0;
    end
  endtask

  task automatic touch(input int d, input int k);
    int piv;
    piv = m_age[d][k];
    for (int i = 0; i < m_n[d]; i++) begin
      if (i == k) m_age[d][i] = 0;
      else if (m_age[d][i] < piv) m_age[d][i] = m_age[d][i] + 1;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One request cycle: drive at the falling edge, compare before the rising edge,
  // then advance the model with the values the design sampled.
  task automatic step(input bit rv, input int ra, input bit vv, input bit vd,
                      input int va, input bit wr, input string tag);
    bit acc [2];
    bit fnd [2];
    int k   [2];
    string t;
    logic [LW-1:0] vdat;
    vdat = line_of(va, vd ? 7 : 3);
    @(negedge clk);
    req_valid = rv; req_addr = AW'(ra); vic_valid = vv; vic_dirty = vd;
    vic_addr = AW'(va); vic_data = vdat; wb_ready = wr;
    #1;
    for (int d = 0; d < 2; d++) begin
      bit rdy_e;
      bit hit_e;
      t = (d == 1) ? {"R4 ", tag} : tag;
      rdy_e = !m_wbv[d] || wr;
      acc[d] = rv && rdy_e;
      fnd[d] = 1'b0; k[d] = 0;
      for (int i = 0; i < m_n[d]; i++)
        if (m_v[d][i] && m_a[d][i] == ra) begin fnd[d] = 1'b1; k[d] = i; end
      hit_e = acc[d] && fnd[d];
      check(rdy[d] == rdy_e, (d == 1) ? "R4 R8" : "R8", "req_ready", 64'(rdy[d]), 64'(rdy_e));
      check(hit[d] == hit_e, t, "hit", 64'(hit[d]), 64'(hit_e));
      if (hit_e && hit[d]) begin
        check(hdat[d] == m_dat[d][k[d]], t, "hit_data", 64'(hdat[d]), 64'(m_dat[d][k[d]]));
        check(hdir[d] == m_d[d][k[d]], t, "hit_dirty", 64'(hdir[d]), 64'(m_d[d][k[d]]));
      end
      check(wbv[d] == m_wbv[d], (d == 1) ? "R4 R7" : "R7", "wb_valid", 64'(wbv[d]), 64'(m_wbv[d]));
      if (m_wbv[d] && wbv[d]) begin
        check(wba[d] == AW'(m_wba[d]), "R7", "wb_addr", 64'(wba[d]), 64'(m_wba[d]));
        check(wbd[d] == m_wbd[d], "R7", "wb_data", 64'(wbd[d]), 64'(m_wbd[d]));
      end
    end
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      if (m_wbv[d] && wr) m_wbv[d] = 1'b0;
      if (acc[d]) begin
        if (fnd[d]) begin
          m_v[d][k[d]] = vv; m_d[d][k[d]] = vv && vd;
          m_a[d][k[d]] = va; m_dat[d][k[d]] = vdat;
          if (vv) touch(d, k[d]);
        end else if (vv) begin
          int sel;
          sel = -1;
          for (int i = m_n[d] - 1; i >= 0; i--) if (!m_v[d][i]) sel = i;
          if (sel < 0)
            for (int i = 0; i < m_n[d]; i++) if (m_age[d][i] == m_n[d] - 1) sel = i;
          if (m_v[d][sel] && m_d[d][sel]) begin
            m_wbv[d] = 1'b1; m_wba[d] = m_a[d][sel]; m_wbd[d] = m_dat[d][sel];
          end
          m_v[d][sel] = 1'b1; m_d[d][sel] = vd; m_a[d][sel] = va; m_dat[d][sel] = vdat;
          touch(d, sel);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: empty after reset, ready, nothing to write back
    step(1'b1, 5, 1'b0, 1'b0, 0, 1'b1, "R9");
    // R6: invalid displaced line on a miss is not kept
    step(1'b1, 5, 1'b0, 1'b0, 6, 1'b1, "R6");
    // R1: displaced line kept, requested line not kept
    step(1'b1, 1, 1'b1, 1'b0, 10, 1'b1, "R1");
    step(1'b1, 1, 1'b0, 1'b0, 0, 1'b1, "R1");
    // R6: hit with an invalid displaced line empties the entry
    step(1'b1, 10, 1'b0, 1'b0, 0, 1'b1, "R6");
    step(1'b1, 10, 1'b0, 1'b0, 0, 1'b1, "R6");
    // R5 / R7: fill past capacity, dirty lines leave through write-back
    step(1'b1, 2, 1'b1, 1'b1, 11, 1'b1, "R5");
    step(1'b1, 3, 1'b1, 1'b0, 12, 1'b1, "R5");
    step(1'b1, 4, 1'b1, 1'b1, 13, 1'b1, "R5");
    step(1'b1, 5, 1'b1, 1'b0, 14, 1'b1, "R7");
    step(1'b1, 6, 1'b1, 1'b0, 15, 1'b1, "R7");
    // R2 / R3: swap, then find the displaced line where the hit was
    step(1'b1, 13, 1'b1, 1'b1, 20, 1'b1, "R2");
    step(1'b1, 13, 1'b0, 1'b0, 0, 1'b1, "R3");
    step(1'b1, 20, 1'b1, 1'b0, 21, 1'b1, "R3");
    step(1'b1, 21, 1'b1, 1'b1, 22, 1'b1, "R2");
    // R8: write-back held off, requests stall and state freezes
    step(1'b1, 30, 1'b1, 1'b1, 40, 1'b0, "R8");
    step(1'b1, 31, 1'b1, 1'b1, 41, 1'b0, "R8");
    step(1'b1, 32, 1'b1, 1'b1, 42, 1'b0, "R8");
    step(1'b1, 33, 1'b1, 1'b1, 43, 1'b0, "R8");
    step(1'b1, 40, 1'b1, 1'b1, 44, 1'b0, "R8");
    step(1'b1, 40, 1'b1, 1'b1, 44, 1'b1, "R8");
    step(1'b0, 0, 1'b0, 1'b0, 0, 1'b1, "R8");
    // R5: pseudo-random sweep over a small address space
    for (int n = 0; n < 4000; n++) begin
      int ra;
      int va;
      bit rv;
      bit vv;
      bit vd;
      bit wr;
      rv = (nextrand() % 8) != 0;
      ra = nextrand() % 16;
      vv = (nextrand() % 8) != 0;
      vd = (nextrand() % 2) != 0;
      wr = (nextrand() % 4) != 0;
      va = (ra + 1 + nextrand() % 7) % 16;
      while (va == ra || in_model(0, va) || in_model(1, va)) va = (va + 1) % 16;
      step(rv, ra, vv, vd, va, wr, "R5");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule